// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and the calendar date as packed BCD fields: seconds, minutes, hours (00–23), weekday (1–7), day of month, month and a two-digit year. It runs on the 32.768 kHz reference clock. A binary prescaler divides that clock down to a one-second tick, and each tick advances the calendar by one second. The carry chain knows the length of every month. It also decides leap years from the two year digits directly: with an odd tens digit, a units digit of 2 or 6 is a leap year; with an even tens digit, a units digit of 0, 4 or 8 is a leap year.

A serial front end, outside this block, talks to the counter through two parallel paths. The first is a 56-bit load image, applied in one cycle on a commit strobe. The second is a snapshot register that captures the live value on request and then stays frozen. While a write transaction is open, the front end raises a hold input. Hold stops the seconds increment and clears the upper divider stages, so counting restarts with a full second once hold is released. The 1 Hz and 2 Hz ticks are brought out for other logic to use.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the calendar reads 00:00:00, weekday 1, day 01, month 01, year 00, with both flag bits 0. The snapshot output reads all zeros.
- R2: With hold low, `tick_1hz_o` is a one-cycle pulse every 2^DIV_W clocks. `tick_2hz_o` pulses every 2^(DIV_W-1) clocks, and it is high in every cycle where `tick_1hz_o` is high.
- R3: Each 1 Hz tick advances the time by one second in BCD. Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours. Hours wrap from 23 to 00 and carry into the day and the weekday. In cycles without a tick or a load, the calendar does not change.
- R4: The weekday advances with each day carry and wraps from 7 to 1.
- R5: The day of month wraps to 01 and carries into the month after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except February.
- R6: In February the day wraps after 29 in a leap year and after 28 otherwise. The leap-year rule is the BCD digit rule given above.
- R7: The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00.
- R8: The load image is one byte per field. Bits 7:0 hold seconds, 15:8 minutes, 23:16 hours, 31:24 week, 39:32 day, 47:40 month and 55:48 year. Week bit 3 is the output-select flag above a 3-bit weekday, and month bit 7 is the test flag. A `load_i` pulse applies the image at the next edge. All bits not named here read back as 0.
- R9: A load in the same cycle as a 1 Hz tick wins: the loaded value appears unincremented.
- R10: While `hold_i` is high, the calendar does not advance, no tick is output, and the divider is cleared from the 128 Hz stage up. After release, the first 1 Hz tick comes 2^DIV_W-1 clocks later (with the bench's DIV_W, the whole divider is cleared).
- R11: `snap_i` copies the live calendar image into `snap_o` at the next edge, and `snap_o` is otherwise unchanged. A capture in the same cycle as a tick takes the value from before the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32.768 kHz reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hold_i | input | 1 | Write in progress: freeze the counters and clear the upper divider |
| load_i | input | 1 | Commit strobe for `load_data_i` |
| load_data_i | input | 56 | Calendar image to load |
| snap_i | input | 1 | Capture strobe for the snapshot |
| snap_o | output | 56 | Captured calendar image |
| tick_1hz_o | output | 1 | One-second tick |
| tick_2hz_o | output | 1 | Half-second tick |

## Verification
Two pairs of functions can land in the same cycle. A commit can coincide with the one-second tick. A snapshot capture can also coincide with that tick. The bench waits until it sees the tick high at a falling edge, then raises `load_i` or `snap_i` for that same cycle. A coinciding load is correct when the loaded value reads back with no increment. A coinciding capture is correct when it returns the pre-increment time and the increment shows up only in a later capture.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int IMG_W = 56;
  localparam logic [IMG_W-1:0] IMG_MASK = 56'hFF9F3F0F3F7F7F;

  typedef struct packed {
    logic [7:0] year;
    logic       test;
    logic [4:0] mon;
    logic [5:0] day;
    logic       fsel;
    logic [2:0] wday;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } cal_t;

  localparam cal_t CAL_RESET = '{year: 8'h00, test: 1'b0, mon: 5'h01, day: 6'h01,
                                 fsel: 1'b0, wday: 3'd1, hour: 6'h00, min: 7'h00,
                                 sec: 7'h00};

  function automatic logic [IMG_W-1:0] cal_to_img(input cal_t c);
    return {c.year, c.test, 2'b00, c.mon, 2'b00, c.day, 4'h0, c.fsel, c.wday,
            2'b00, c.hour, 1'b0, c.min, 1'b0, c.sec};
  endfunction

  function automatic cal_t img_to_cal(input logic [IMG_W-1:0] v);
    cal_t c;
    c.sec  = v[6:0];
    c.min  = v[14:8];
    c.hour = v[21:16];
    c.wday = v[26:24];
    c.fsel = v[27];
    c.day  = v[37:32];
    c.mon  = v[44:40];
    c.test = v[47];
    c.year = v[55:48];
    return c;
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    logic [3:0] u;
    u = yr[3:0];
    if (yr[4]) return (u == 4'd2) || (u == 4'd6);
    return (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
  endfunction

  function automatic logic [5:0] last_day(input logic [4:0] mon, input logic [7:0] yr);
    case (mon)
      5'h02:                      return is_leap(yr) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_W       = 15,
  parameter int HOLD_STAGES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic tick_1hz_o,
  output logic tick_2hz_o
);
  localparam int HOLD_LO = (DIV_W > HOLD_STAGES) ? DIV_W - HOLD_STAGES : 0;
  localparam logic [DIV_W-1:0] KEEP = DIV_W'((64'd1 << HOLD_LO) - 64'd1);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (hold_i) div_q <= (div_q + 1'b1) & KEEP;  // lower stages free-run
    else             div_q <= div_q + 1'b1;
  end

  assign tick_1hz_o = (&div_q) & ~hold_i;
  assign tick_2hz_o = (&div_q[DIV_W-2:0]) & ~hold_i;
endmodule

// File: rtl/rtc_cal_next.sv
module rtc_cal_next
  import rtc_cal_pkg::*;
(
  input  cal_t cal_i,
  output cal_t cal_o
);
  logic wrap_s, wrap_m, wrap_h, wrap_d, wrap_mo;
  logic [5:0] eom;

  always_comb begin
    eom     = last_day(cal_i.mon, cal_i.year);
    wrap_s  = cal_i.sec  >= 7'h59;
    wrap_m  = wrap_s && (cal_i.min  >= 7'h59);
    wrap_h  = wrap_m && (cal_i.hour >= 6'h23);
    wrap_d  = wrap_h && (cal_i.day  >= eom);
    wrap_mo = wrap_d && (cal_i.mon  >= 5'h12);

    cal_o = cal_i;

    if (wrap_s)                  cal_o.sec = '0;
    else if (cal_i.sec[3:0] >= 4'd9) cal_o.sec = {cal_i.sec[6:4] + 3'd1, 4'd0};
    else                         cal_o.sec = {cal_i.sec[6:4], cal_i.sec[3:0] + 4'd1};

    if (wrap_s) begin
      if (wrap_m)                        cal_o.min = '0;
      else if (cal_i.min[3:0] >= 4'd9)   cal_o.min = {cal_i.min[6:4] + 3'd1, 4'd0};
      else                               cal_o.min = {cal_i.min[6:4], cal_i.min[3:0] + 4'd1};
    end

    if (wrap_m) begin
      if (wrap_h)                        cal_o.hour = '0;
      else if (cal_i.hour[3:0] >= 4'd9)  cal_o.hour = {cal_i.hour[5:4] + 2'd1, 4'd0};
      else                               cal_o.hour = {cal_i.hour[5:4], cal_i.hour[3:0] + 4'd1};
    end

    if (wrap_h) begin
      cal_o.wday = (cal_i.wday >= 3'd7) ? 3'd1 : cal_i.wday + 3'd1;
      if (wrap_d)                        cal_o.day = 6'h01;
      else if (cal_i.day[3:0] >= 4'd9)   cal_o.day = {cal_i.day[5:4] + 2'd1, 4'd0};
      else                               cal_o.day = {cal_i.day[5:4], cal_i.day[3:0] + 4'd1};
    end

    if (wrap_d) begin
      if (wrap_mo)                       cal_o.mon = 5'h01;
      else if (cal_i.mon[3:0] >= 4'd9)   cal_o.mon = 5'h10;
      else                               cal_o.mon = {cal_i.mon[4], cal_i.mon[3:0] + 4'd1};
    end

    if (wrap_mo) begin
      if (cal_i.year >= 8'h99)           cal_o.year = '0;
      else if (cal_i.year[3:0] >= 4'd9)  cal_o.year = {cal_i.year[7:4] + 4'd1, 4'd0};
      else                               cal_o.year = {cal_i.year[7:4], cal_i.year[3:0] + 4'd1};
    end
  end
endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot #(
  parameter int W = 56
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (cap_i) q_o <= d_i;
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int DIV_W       = 15,
  parameter int HOLD_STAGES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             load_i,
  input  logic [IMG_W-1:0] load_data_i,
  input  logic             snap_i,
  output logic [IMG_W-1:0] snap_o,
  output logic             tick_1hz_o,
  output logic             tick_2hz_o
);
  cal_t             cal_q, cal_nx;
  logic [IMG_W-1:0] live_img;

  rtc_prescaler #(.DIV_W(DIV_W), .HOLD_STAGES(HOLD_STAGES)) u_div (
    .clk_i, .rst_ni, .hold_i, .tick_1hz_o, .tick_2hz_o
  );

  rtc_cal_next u_next (.cal_i(cal_q), .cal_o(cal_nx));

  // load outranks the tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cal_q <= CAL_RESET;
    else if (load_i)     cal_q <= img_to_cal(load_data_i);
    else if (tick_1hz_o) cal_q <= cal_nx;
  end

  assign live_img = cal_to_img(cal_q);

  rtc_snapshot #(.W(IMG_W)) u_snap (
    .clk_i, .rst_ni, .cap_i(snap_i), .d_i(live_img), .q_o(snap_o)
  );
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_cal_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hold_i,
  input logic             load_i,
  input logic [IMG_W-1:0] load_data_i,
  input logic             snap_i,
  input logic [IMG_W-1:0] snap_o,
  input logic             tick_1hz_o,
  input logic             tick_2hz_o,
  input logic [IMG_W-1:0] live_img
);
  assert_tick_nest_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_1hz_o |-> tick_2hz_o);

  assert_tick_moves_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_1hz_o && !load_i) |=> live_img[6:0] != $past(live_img[6:0]));

  assert_idle_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_1hz_o && !load_i) |=> $stable(live_img));

  assert_load_apply_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> live_img == ($past(load_data_i) & IMG_MASK));

  assert_hold_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !load_i) |=> $stable(live_img));

  assert_hold_no_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> (!tick_1hz_o && !tick_2hz_o));

  assert_snap_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(snap_o));

  assert_snap_take_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> snap_o == $past(live_img));
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold_i), .load_i(load_i),
  .load_data_i(load_data_i), .snap_i(snap_i), .snap_o(snap_o),
  .tick_1hz_o(tick_1hz_o), .tick_2hz_o(tick_2hz_o), .live_img(live_img)
);

// File: tb/rtc_calendar_test.sv
module rtc_calendar_test;
  localparam int DIV_W = 6;
  localparam int SEC   = 1 << DIV_W;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hold_i = 1'b0;
  logic        load_i = 1'b0;
  logic [55:0] load_data_i = '0;
  logic        snap_i = 1'b0;
  logic [55:0] snap_o;
  logic        tick_1hz_o, tick_2hz_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #10ns clk_i = ~clk_i;

  rtc_calendar #(.DIV_W(DIV_W)) uut (
    .clk_i, .rst_ni, .hold_i, .load_i, .load_data_i, .snap_i, .snap_o,
    .tick_1hz_o, .tick_2hz_o
  );

  function automatic logic [55:0] mk(input logic [7:0] yr, mo, dy, wk, hr, mi, se);
    return {yr, mo, dy, wk, hr, mi, se};
  endfunction

  task automatic chk(input string req, input logic [55:0] act, input logic [55:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cap(output logic [55:0] v);
    @(negedge clk_i) snap_i = 1'b1;
    @(negedge clk_i) snap_i = 1'b0;
    v = snap_o;
  endtask

  task automatic set_time(input logic [55:0] img);
    @(negedge clk_i) begin hold_i = 1'b1; load_i = 1'b1; load_data_i = img; end
    @(negedge clk_i) load_i = 1'b0;
    @(negedge clk_i) hold_i = 1'b0;
  endtask

  task automatic wait_tick();
    for (int i = 0; i < 4 * SEC && !tick_1hz_o; i++) @(negedge clk_i);
  endtask

  task automatic step_check(input string req, input logic [55:0] from, input logic [55:0] exp);
    logic [55:0] v;
    set_time(from);
    wait_tick();
    @(negedge clk_i);
    cap(v);
    chk(req, v, exp);
  endtask

  task automatic t_reset();
    logic [55:0] v;
    chk("R1 snapshot after reset", snap_o, '0);
    chk("R1 no tick after reset", {55'd0, tick_1hz_o}, '0);
    cap(v);
    chk("R1 reset calendar", v, mk(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00));
  endtask

  task automatic t_period();
    int n, n2;
    wait_tick();
    n = 0; n2 = 0;
    do begin
      @(negedge clk_i);
      n++;
      if (tick_2hz_o) n2++;
    end while (!tick_1hz_o && n < 4 * SEC);
    chk("R2 1 Hz period", 56'(n), 56'(SEC));
    chk("R2 2 Hz pulses per second", 56'(n2), 56'd2);
  endtask

  task automatic t_rollover();
    step_check("R3 plain second", mk(8'h24, 8'h03, 8'h10, 8'h02, 8'h12, 8'h34, 8'h56),
               mk(8'h24, 8'h03, 8'h10, 8'h02, 8'h12, 8'h34, 8'h57));
    step_check("R3 second to minute", mk(8'h24, 8'h03, 8'h10, 8'h02, 8'h12, 8'h39, 8'h59),
               mk(8'h24, 8'h03, 8'h10, 8'h02, 8'h12, 8'h40, 8'h00));
    step_check("R3 minute to hour", mk(8'h24, 8'h03, 8'h10, 8'h02, 8'h09, 8'h59, 8'h59),
               mk(8'h24, 8'h03, 8'h10, 8'h02, 8'h10, 8'h00, 8'h00));
    step_check("R4 weekday 7 to 1", mk(8'h24, 8'h03, 8'h19, 8'h07, 8'h23, 8'h59, 8'h59),
               mk(8'h24, 8'h03, 8'h20, 8'h01, 8'h00, 8'h00, 8'h00));
  endtask

  task automatic t_months();
    step_check("R5 April ends at 30", mk(8'h24, 8'h04, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59),
               mk(8'h24, 8'h05, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00));
    step_check("R5 January 30 to 31", mk(8'h24, 8'h01, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59),
               mk(8'h24, 8'h01, 8'h31, 8'h04, 8'h00, 8'h00, 8'h00));
    step_check("R5 September to October", mk(8'h24, 8'h09, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59),
               mk(8'h24, 8'h10, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00));
  endtask

  task automatic t_leap();
    step_check("R6 year 23 Feb 28", mk(8'h23, 8'h02, 8'h28, 8'h05, 8'h23, 8'h59, 8'h59),
               mk(8'h23, 8'h03, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00));
    step_check("R6 year 24 Feb 28", mk(8'h24, 8'h02, 8'h28, 8'h05, 8'h23, 8'h59, 8'h59),
               mk(8'h24, 8'h02, 8'h29, 8'h06, 8'h00, 8'h00, 8'h00));
    step_check("R6 year 12 Feb 28", mk(8'h12, 8'h02, 8'h28, 8'h05, 8'h23, 8'h59, 8'h59),
               mk(8'h12, 8'h02, 8'h29, 8'h06, 8'h00, 8'h00, 8'h00));
    step_check("R6 year 10 Feb 28", mk(8'h10, 8'h02, 8'h28, 8'h05, 8'h23, 8'h59, 8'h59),
               mk(8'h10, 8'h03, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00));
    step_check("R6 year 24 Feb 29", mk(8'h24, 8'h02, 8'h29, 8'h06, 8'h23, 8'h59, 8'h59),
               mk(8'h24, 8'h03, 8'h01, 8'h07, 8'h00, 8'h00, 8'h00));
  endtask

  task automatic t_year();
    step_check("R7 December 31 year 99", mk(8'h99, 8'h12, 8'h31, 8'h04, 8'h23, 8'h59, 8'h59),
               mk(8'h00, 8'h01, 8'h01, 8'h05, 8'h00, 8'h00, 8'h00));
    step_check("R7 December to year 20", mk(8'h19, 8'h12, 8'h31, 8'h04, 8'h23, 8'h59, 8'h59),
               mk(8'h20, 8'h01, 8'h01, 8'h05, 8'h00, 8'h00, 8'h00));
  endtask

  task automatic t_load();
    logic [55:0] v;
    @(negedge clk_i) begin hold_i = 1'b1; load_i = 1'b1; load_data_i = '1; end
    @(negedge clk_i) load_i = 1'b0;
    cap(v);
    chk("R8 unused bits read 0", v, 56'hFF9F3F0F3F7F7F);
    step_check("R8 flags kept through tick", mk(8'h45, 8'h87, 8'h15, 8'h0B, 8'h10, 8'h20, 8'h30),
               mk(8'h45, 8'h87, 8'h15, 8'h0B, 8'h10, 8'h20, 8'h31));
  endtask

  task automatic t_load_vs_tick();
    logic [55:0] v;
    set_time(mk(8'h30, 8'h06, 8'h15, 8'h03, 8'h08, 8'h00, 8'h00));
    wait_tick();
    load_i = 1'b1;
    load_data_i = mk(8'h31, 8'h07, 8'h04, 8'h06, 8'h18, 8'h45, 8'h10);
    @(negedge clk_i) load_i = 1'b0;
    cap(v);
    chk("R9 load beats tick", v, mk(8'h31, 8'h07, 8'h04, 8'h06, 8'h18, 8'h45, 8'h10));
  endtask

  task automatic t_hold();
    logic [55:0] v;
    int seen, n;
    set_time(mk(8'h50, 8'h08, 8'h20, 8'h01, 8'h11, 8'h11, 8'h11));
    @(negedge clk_i) hold_i = 1'b1;
    seen = 0;
    for (int i = 0; i < 3 * SEC; i++) begin
      @(negedge clk_i);
      if (tick_1hz_o || tick_2hz_o) seen++;
    end
    chk("R10 no tick while held", 56'(seen), 56'd0);
    cap(v);
    chk("R10 frozen while held", v, mk(8'h50, 8'h08, 8'h20, 8'h01, 8'h11, 8'h11, 8'h11));
    hold_i = 1'b0;
    n = 0;
    do begin
      @(posedge clk_i);
      n++;
      @(negedge clk_i);
    end while (!tick_1hz_o && n < 4 * SEC);
    chk("R10 restart delay", 56'(n), 56'(SEC - 1));
    @(negedge clk_i);
    cap(v);
    chk("R10 advance after release", v, mk(8'h50, 8'h08, 8'h20, 8'h01, 8'h11, 8'h11, 8'h12));
  endtask

  task automatic t_snap_vs_tick();
    logic [55:0] v;
    set_time(mk(8'h33, 8'h11, 8'h05, 8'h02, 8'h12, 8'h00, 8'h00));
    wait_tick();
    snap_i = 1'b1;
    @(negedge clk_i) snap_i = 1'b0;
    chk("R11 capture with tick is pre-increment", snap_o,
        mk(8'h33, 8'h11, 8'h05, 8'h02, 8'h12, 8'h00, 8'h00));
    repeat (5) @(negedge clk_i);
    chk("R11 snapshot held", snap_o, mk(8'h33, 8'h11, 8'h05, 8'h02, 8'h12, 8'h00, 8'h00));
    cap(v);
    chk("R11 later capture shows increment", v,
        mk(8'h33, 8'h11, 8'h05, 8'h02, 8'h12, 8'h00, 8'h01));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_period();
    t_rollover();
    t_months();
    t_leap();
    t_year();
    t_load();
    t_load_vs_tick();
    t_hold();
    t_snap_vs_tick();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule